// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Slave Interface

This block is the slave-side front end of a peripheral on a shared 8-bit address/data bus. The host first places an address on the bus and pulses an address strobe. It then runs a data phase that either reads a register or writes one. A static mode pin chooses between two timing conventions. In strobe-qualified mode (`mode_strobe` = 1), a positive data strobe marks the data phase and the read/write level gives its direction. In enable-style mode (`mode_strobe` = 0), the data strobe is an active-low output enable and the read/write line is an active-low write enable. Writes are latched on the rising edge of the write enable in this mode.

All bus pins are asynchronous. Each one passes through a two-flop synchronizer clocked by the fast system clock, and a finite state machine then walks through the access. The states are `ST_IDLE` (no address held), `ST_ADDR` (address held, waiting for a data phase), `ST_RDREQ` (one-cycle register read request), `ST_READ` (bus driven), `ST_WRITE` (write phase open), `ST_WRCOMMIT` (one-cycle register write strobe) and `ST_SKIP` (unselected data phase being waited out).

The transitions are as follows:
- A falling address strobe moves `ST_IDLE` or `ST_ADDR` to `ST_ADDR`.
- A rising address strobe moves `ST_ADDR` to `ST_IDLE`.
- When a data phase starts, `ST_ADDR` moves to `ST_RDREQ`, `ST_WRITE` or `ST_SKIP`, depending on direction and selection.
- `ST_RDREQ` always moves to `ST_READ`.
- When the read ends, `ST_READ` moves to `ST_IDLE`.
- When the write ends, `ST_WRITE` moves to `ST_WRCOMMIT`.
- `ST_WRCOMMIT` moves to `ST_IDLE`.
- When the phase ends, `ST_SKIP` moves to `ST_IDLE`.

The register file sits outside the block. It must present read data combinationally from `reg_addr` while `reg_rd` is high.

Top module: `mbus_slave_if`

## Requirements
- R1: A falling edge of `as_i` captures `ad_in` into `reg_addr`.
- R2: A rising edge of `as_i` while no access is open clears `reg_addr` to zero, whatever the level of `cs_n_i`.
- R3: In strobe-qualified mode, a selected read (`rw_i` = 1 while `ds_i` = 1) gives exactly one `reg_rd` pulse. It then drives the read data on `ad_out` with `ad_oe` = 1 while `ds_i` stays high, and drops `ad_oe` after `ds_i` falls.
- R4: In strobe-qualified mode, a selected write (`rw_i` = 0 during `ds_i` high) gives exactly one `reg_wr` pulse. The pulse carries the held address and the bus value present when `ds_i` falls.
- R5: In enable-style mode, `ds_i` = 0 with `rw_i` = 1 is a selected read. The bus is driven with exactly one `reg_rd` pulse and released after `ds_i` returns high.
- R6: In enable-style mode, a low pulse on `rw_i` is a write. The write is committed only after `rw_i` rises, with the bus value present at that rise.
- R7: A data phase with `cs_n_i` = 1 gives no register strobe and no drive. It also consumes the address, so a later selected data phase with no new address strobe has no effect.
- R8: While `pfail` is 1, no register read or write strobe is produced.
- R9: While `rst_n` is 0, `reg_rd`, `reg_wr` and `ad_oe` are 0, `reg_addr` is 0, and no access is accepted.
- R10: After a completed access, a further data phase with no new address strobe gives no register strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock used to sample the bus |
| rst_n | input | 1 | Active-low reset; blocks all access while low |
| mode_strobe | input | 1 | 1 = strobe-qualified timing, 0 = enable-style timing |
| pfail | input | 1 | Power-fail inhibit; forces the chip select inactive |
| as_i | input | 1 | Address strobe |
| ds_i | input | 1 | Data strobe (mode 1) or active-low output enable (mode 0) |
| rw_i | input | 1 | Read/write level (mode 1) or active-low write enable (mode 0) |
| cs_n_i | input | 1 | Active-low chip select |
| ad_in | input | DW | Address/data bus as seen from the pads |
| ad_out | output | DW | Read data for the pad drivers |
| ad_oe | output | 1 | Pad output enable |
| reg_addr | output | DW | Latched register address |
| reg_rd | output | 1 | One-cycle register read request |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | DW | Write data for the register file |
| reg_rdata | input | DW | Read data from the register file |

## Verification
A pin change is seen by the state register on the third rising clock edge after it: two synchronizer stages, then the state update. `reg_addr`, `reg_rd`, `ad_oe` and the write commit therefore move three edges after their causing pin edge. `ad_oe` comes one edge later than `reg_rd`. The bench drives pins just after a falling clock edge and holds every level for six clock periods before sampling on a falling edge. Every expected result has settled by then, and no pin is still in flight. Register strobes are counted by a bench monitor on every rising edge, so a missing or doubled pulse shows up as a wrong count.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RDREQ,
        ST_READ,
        ST_WRITE,
        ST_WRCOMMIT,
        ST_SKIP
    } bus_state_e;

    localparam int CTRL_BITS = 5;

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int         W       = 4,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= RST_VAL;
            end
        end else begin
            stg[0] <= d_in;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q_out = stg[STAGES-1];

endmodule

// File: rtl/mbus_fsm.sv
module mbus_fsm
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_strobe,
    input  logic       as_fall,
    input  logic       as_rise,
    input  logic       ds_s,
    input  logic       rw_s,
    input  logic       sel_s,
    output bus_state_e state,
    output logic       reg_rd,
    output logic       reg_wr,
    output logic       ad_oe,
    output logic       addr_open,
    output logic       cap_wdata,
    output logic       cap_rdata
);

    bus_state_e state_q, state_d;
    logic phase_start, phase_read, rd_end, wr_end, skip_end;

    // Data-phase decoding for each timing convention
    always_comb begin
        if (mode_strobe) begin
            phase_start = ds_s;
            phase_read  = rw_s;
            rd_end      = !ds_s;
            wr_end      = !ds_s;
            skip_end    = !ds_s;
        end else begin
            phase_start = !rw_s || !ds_s;
            phase_read  = rw_s;
            rd_end      = ds_s;
            wr_end      = rw_s;
            skip_end    = ds_s && rw_s;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (as_fall) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (as_fall)          state_d = ST_ADDR;
                else if (as_rise)     state_d = ST_IDLE;
                else if (phase_start) begin
                    if (!sel_s)          state_d = ST_SKIP;
                    else if (phase_read) state_d = ST_RDREQ;
                    else                 state_d = ST_WRITE;
                end
            end
            ST_RDREQ:    state_d = ST_READ;
            ST_READ: begin
                if (rd_end) state_d = ST_IDLE;
            end
            ST_WRITE: begin
                if (wr_end) state_d = ST_WRCOMMIT;
            end
            ST_WRCOMMIT: state_d = ST_IDLE;
            ST_SKIP: begin
                if (skip_end) state_d = ST_IDLE;
            end
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        reg_rd    = (state_q == ST_RDREQ);
        reg_wr    = (state_q == ST_WRCOMMIT);
        ad_oe     = (state_q == ST_READ);
        addr_open = (state_q == ST_IDLE) || (state_q == ST_ADDR);
        cap_wdata = (state_q == ST_WRITE) && wr_end;
        cap_rdata = (state_q == ST_RDREQ);
    end

    assign state = state_q;

endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          as_fall,
    input  logic          as_rise,
    input  logic          addr_open,
    input  logic          cap_wdata,
    input  logic          cap_rdata,
    input  logic [DW-1:0] ad_s,
    input  logic [DW-1:0] reg_rdata,
    output logic [DW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (as_fall) begin
            addr_q <= ad_s;
        end else if (as_rise && addr_open) begin
            addr_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (cap_wdata) wdata_q <= ad_s;
            if (cap_rdata) rdata_q <= reg_rdata;
        end
    end

endmodule

// File: rtl/mbus_slave_if.sv
module mbus_slave_if
    import mbus_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_strobe,
    input  logic          pfail,
    input  logic          as_i,
    input  logic          ds_i,
    input  logic          rw_i,
    input  logic          cs_n_i,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [DW-1:0] reg_addr,
    output logic          reg_rd,
    output logic          reg_wr,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata
);

    localparam int NB = CTRL_BITS + DW;
    // Reset levels: as=0, ds=0, rw=1, cs_n=1, pfail=0, bus=0
    localparam logic [NB-1:0] SYNC_RST = {5'b00110, {DW{1'b0}}};

    logic [NB-1:0] sync_in, sync_out;
    logic          as_s, ds_s, rw_s, cs_n_s, pfail_s, as_d;
    logic [DW-1:0] ad_s;
    logic          as_fall, as_rise, sel_s;
    logic          addr_open, cap_wdata, cap_rdata;
    logic [DW-1:0] wdata_q, rdata_q;
    bus_state_e    state;

    assign sync_in = {as_i, ds_i, rw_i, cs_n_i, pfail, ad_in};

    mbus_sync #(.W(NB), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (sync_in),
        .q_out (sync_out)
    );

    assign {as_s, ds_s, rw_s, cs_n_s, pfail_s, ad_s} = sync_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) as_d <= 1'b0;
        else        as_d <= as_s;
    end

    assign as_fall = as_d && !as_s;
    assign as_rise = !as_d && as_s;
    assign sel_s   = !cs_n_s && !pfail_s;

    mbus_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_strobe (mode_strobe),
        .as_fall     (as_fall),
        .as_rise     (as_rise),
        .ds_s        (ds_s),
        .rw_s        (rw_s),
        .sel_s       (sel_s),
        .state       (state),
        .reg_rd      (reg_rd),
        .reg_wr      (reg_wr),
        .ad_oe       (ad_oe),
        .addr_open   (addr_open),
        .cap_wdata   (cap_wdata),
        .cap_rdata   (cap_rdata)
    );

    mbus_datapath #(.DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_fall   (as_fall),
        .as_rise   (as_rise),
        .addr_open (addr_open),
        .cap_wdata (cap_wdata),
        .cap_rdata (cap_rdata),
        .ad_s      (ad_s),
        .reg_rdata (reg_rdata),
        .addr_q    (reg_addr),
        .wdata_q   (wdata_q),
        .rdata_q   (rdata_q)
    );

    assign reg_wdata = wdata_q;
    assign ad_out    = rdata_q;

endmodule

// File: rtl/mbus_slave_if_chk.sv
module mbus_slave_if_chk (
    input logic clk,
    input logic rst_n,
    input logic pfail,
    input logic reg_rd,
    input logic reg_wr,
    input logic ad_oe
);

    AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);                                   // R3

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);                                   // R4

    AST_OE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe) |-> $past(reg_rd));                       // R5

    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));                                  // R10

    AST_PFAIL_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pfail, 3) |-> !reg_rd);                          // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!reg_rd && !reg_wr && !ad_oe));            // R9

endmodule

bind mbus_slave_if mbus_slave_if_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pfail  (pfail),
    .reg_rd (reg_rd),
    .reg_wr (reg_wr),
    .ad_oe  (ad_oe)
);

// File: tb/mbus_slave_if_test.sv
module mbus_slave_if_test;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_strobe = 1'b1;
    logic          pfail = 1'b0;
    logic          as_i = 1'b0, ds_i = 1'b0, rw_i = 1'b1, cs_n_i = 1'b1;
    logic [DW-1:0] ad_in = '0;
    logic [DW-1:0] ad_out, reg_addr, reg_wdata, reg_rdata;
    logic          ad_oe, reg_rd, reg_wr;

    logic [DW-1:0] mem [256];
    int            rd_cnt = 0, wr_cnt = 0;
    int            n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    mbus_slave_if uut (
        .clk(clk), .rst_n(rst_n), .mode_strobe(mode_strobe), .pfail(pfail),
        .as_i(as_i), .ds_i(ds_i), .rw_i(rw_i), .cs_n_i(cs_n_i), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
    end

    always @(posedge clk) begin
        if (reg_rd) rd_cnt <= rd_cnt + 1;
        if (reg_wr) begin
            wr_cnt <= wr_cnt + 1;
            mem[reg_addr] <= reg_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic addr_phase(input logic [DW-1:0] a);
        ad_in = a; as_i = 1'b1; wait_cyc(6);
        as_i = 1'b0; wait_cyc(6);
    endtask

    // Strobe-qualified write: rw low, ds pulse
    task automatic s_write(input logic [DW-1:0] d);
        rw_i = 1'b0; ad_in = d; ds_i = 1'b1; wait_cyc(6);
        ds_i = 1'b0; wait_cyc(6);
        rw_i = 1'b1; wait_cyc(2);
    endtask

    // Enable-style write: rw low pulse
    task automatic e_write(input logic [DW-1:0] d);
        ad_in = d; rw_i = 1'b0; wait_cyc(6);
        rw_i = 1'b1; wait_cyc(6);
    endtask

    task automatic t_reset;
        chk(reg_rd == 0 && reg_wr == 0 && ad_oe == 0, "R9 strobes in reset", {reg_rd, reg_wr, ad_oe}, 0);
        chk(reg_addr == 0, "R9 addr in reset", reg_addr, 0);
        // access attempt while held in reset
        cs_n_i = 1'b0; addr_phase(8'h21); s_write(8'h99);
        chk(wr_cnt == 0 && reg_addr == 0, "R9 no access in reset", wr_cnt, 0);
        cs_n_i = 1'b1;
        rst_n = 1'b1; wait_cyc(4);
    endtask

    task automatic t_addr;
        mode_strobe = 1'b1; cs_n_i = 1'b1;
        ad_in = 8'h35; as_i = 1'b1; wait_cyc(6);
        as_i = 1'b0; wait_cyc(6);
        chk(reg_addr == 8'h35, "R1 address capture", reg_addr, 8'h35);
        as_i = 1'b1; wait_cyc(6);
        chk(reg_addr == 8'h00, "R2 address clear", reg_addr, 0);
        as_i = 1'b0; wait_cyc(6);
    endtask

    task automatic t_strobe_write;
        int w0;
        w0 = wr_cnt;
        mode_strobe = 1'b1; cs_n_i = 1'b0;
        addr_phase(8'h12); s_write(8'hA5);
        chk(wr_cnt == w0 + 1, "R4 one write pulse", wr_cnt - w0, 1);
        chk(mem[8'h12] == 8'hA5, "R4 write data", mem[8'h12], 8'hA5);
        cs_n_i = 1'b1;
    endtask

    task automatic t_strobe_read;
        int r0;
        r0 = rd_cnt;
        mode_strobe = 1'b1; cs_n_i = 1'b0;
        addr_phase(8'h12);
        rw_i = 1'b1; ad_in = 8'h00; ds_i = 1'b1; wait_cyc(6);
        chk(ad_oe == 1'b1, "R3 drive while ds high", ad_oe, 1);
        chk(ad_out == 8'hA5, "R3 read data", ad_out, 8'hA5);
        chk(rd_cnt == r0 + 1, "R3 one read pulse", rd_cnt - r0, 1);
        ds_i = 1'b0; wait_cyc(6);
        chk(ad_oe == 1'b0, "R3 release after ds falls", ad_oe, 0);
        cs_n_i = 1'b1;
    endtask

    task automatic t_enable_write;
        int w0;
        mode_strobe = 1'b0; ds_i = 1'b1; rw_i = 1'b1; cs_n_i = 1'b0;
        wait_cyc(4);
        addr_phase(8'h7E);
        w0 = wr_cnt;
        ad_in = 8'h3C; rw_i = 1'b0; wait_cyc(6);
        chk(wr_cnt == w0, "R6 no commit while rw low", wr_cnt - w0, 0);
        rw_i = 1'b1; wait_cyc(6);
        chk(wr_cnt == w0 + 1, "R6 one write at rw rise", wr_cnt - w0, 1);
        chk(mem[8'h7E] == 8'h3C, "R6 write data", mem[8'h7E], 8'h3C);
        cs_n_i = 1'b1;
    endtask

    task automatic t_enable_read;
        int r0;
        mode_strobe = 1'b0; ds_i = 1'b1; rw_i = 1'b1; cs_n_i = 1'b0;
        addr_phase(8'h7E);
        r0 = rd_cnt;
        ds_i = 1'b0; wait_cyc(6);
        chk(ad_oe == 1'b1 && ad_out == 8'h3C, "R5 drive while ds low", ad_out, 8'h3C);
        chk(rd_cnt == r0 + 1, "R5 one read pulse", rd_cnt - r0, 1);
        ds_i = 1'b1; wait_cyc(6);
        chk(ad_oe == 1'b0, "R5 release after ds rises", ad_oe, 0);
        cs_n_i = 1'b1;
    endtask

    task automatic t_unselected;
        int w0;
        mode_strobe = 1'b1; ds_i = 1'b0; rw_i = 1'b1; wait_cyc(4);
        w0 = wr_cnt;
        cs_n_i = 1'b1;
        addr_phase(8'h12); s_write(8'hFF);
        chk(wr_cnt == w0 && ad_oe == 1'b0, "R7 unselected phase inert", wr_cnt - w0, 0);
        cs_n_i = 1'b0;
        s_write(8'hEE);
        chk(wr_cnt == w0, "R7 no access without new strobe", wr_cnt - w0, 0);
        chk(mem[8'h12] == 8'hA5, "R7 register unchanged", mem[8'h12], 8'hA5);
        cs_n_i = 1'b1;
    endtask

    task automatic t_consume;
        int w0;
        mode_strobe = 1'b1; cs_n_i = 1'b0;
        addr_phase(8'h44); s_write(8'h11);
        w0 = wr_cnt;
        s_write(8'h22);
        chk(wr_cnt == w0, "R10 second phase ignored", wr_cnt - w0, 0);
        chk(mem[8'h44] == 8'h11, "R10 register keeps first write", mem[8'h44], 8'h11);
        cs_n_i = 1'b1;
    endtask

    task automatic t_pfail;
        int r0, w0;
        mode_strobe = 1'b1; cs_n_i = 1'b0; pfail = 1'b1; wait_cyc(4);
        r0 = rd_cnt; w0 = wr_cnt;
        addr_phase(8'h12);
        rw_i = 1'b1; ds_i = 1'b1; wait_cyc(6);
        chk(ad_oe == 1'b0 && rd_cnt == r0, "R8 read blocked", rd_cnt - r0, 0);
        ds_i = 1'b0; wait_cyc(6);
        addr_phase(8'h12); s_write(8'h55);
        chk(wr_cnt == w0, "R8 write blocked", wr_cnt - w0, 0);
        chk(mem[8'h12] == 8'hA5, "R8 register unchanged", mem[8'h12], 8'hA5);
        pfail = 1'b0; cs_n_i = 1'b1; wait_cyc(4);
    endtask

    initial begin
        wait_cyc(3);
        t_reset();
        t_addr();
        t_strobe_write();
        t_strobe_read();
        t_enable_write();
        t_enable_read();
        t_unselected();
        t_consume();
        t_pfail();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule